// File: doc/BRIEF.md
# Clock Source Status Register

This block holds the two read-only status words of a multi-source audio clocking unit. One word, the source summary, carries a live lock flag and a sticky slip-error flag for each of eleven external clock sources. The other word, the selected-source status, carries the lock flag of the source that is currently selected together with the nominal sample-rate code measured for it.

Lock inputs arrive asynchronously and pass through a two-flop synchronizer. Slip-error pulses are synchronous to the block clock and are held until software reads the summary word with a single-quadlet read; a block read returns the same value but leaves the sticky flags in place. Two one-cycle event pulses feed the notification logic: one when any source's lock flag changes, one when the lock flag of the selected source changes. Slip errors never raise an event.

Top module: `clk_src_status`

## Requirements
- R1: In the summary word (read with `rd_sel`=0), bit i (i = 0..10) is the synchronized lock state of source i, in the source order AES1, AES2, AES3, AES4, ADAT, TDIF, ARX1, ARX2, ARX3, ARX4, word clock. A change on `lock_async` reaches the word two clock edges after it is sampled.
- R2: A pulse on `slip_pulse[i]` sets summary bit 16+i, same source order as R1. The bit stays set until a clearing read, whatever the lock state.
- R3: A single-quadlet read of the summary word (`rd_en`=1, `rd_sel`=0, `rd_block`=0) returns the sticky slip bits as they were and clears them afterwards.
- R4: A block read of the summary word (`rd_block`=1) returns the same value and clears no slip bit.
- R5: A slip pulse in the same cycle as a clearing read is not returned by that read, but its bit is set afterwards, so no error is lost.
- R6: `ev_ext_lock` is high for one cycle after any summary lock bit changes (the cycle in which the new lock word is visible). Slip pulses never raise it.
- R7: The selected-source word (`rd_sel`=1) has the selected source's lock flag in bit 0 and `rate_code` in bits 15:8. Rate codes 0 to 6 stand for 32, 44.1, 48, 88.2, 96, 176.4 and 192 kHz, and 0x0A stands for no rate. A `cur_src` value of 11 or more selects the internal clock, which counts as always locked.
- R8: `ev_cur_lock` is high for one cycle one clock after the selected-source lock flag changes. This applies to a lock change on the selected source and to a change of `cur_src` onto a source with a different lock state.
- R9: Read data appears with `rd_valid` high one cycle after `rd_en`. All bits not named in R1, R2 and R7 read as zero.
- R10: After reset, both words read as zero except the rate field, all slip bits are clear, and neither event output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_async | input | 11 | Per-source lock state, asynchronous |
| slip_pulse | input | 11 | Per-source slip-error pulses, synchronous |
| cur_src | input | 4 | Index of the selected source (11 or more = internal) |
| rate_code | input | 8 | Measured nominal-rate code |
| rd_en | input | 1 | Read request |
| rd_sel | input | 1 | 0 = source summary word, 1 = selected-source word |
| rd_block | input | 1 | 1 = read is part of a block read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| ev_ext_lock | output | 1 | Pulse: some source's lock state changed |
| ev_cur_lock | output | 1 | Pulse: selected source's lock state changed |

## Verification
A lost or stuck sticky flag shows up as a wrong bit 16+i at the very next read of the summary word. A clear done on the wrong kind of read shows up at the second of two back-to-back reads. A synchronizer fault or a broken change detector moves or removes the event pulse by a cycle, which can be seen at `ev_ext_lock` two edges after the lock input moves and at `ev_cur_lock` one edge later. A wrong select or padding mapping gives a wrong bit 0 in the selected-source word as soon as it is read after the source is switched.

// File: rtl/clk_src_status.sv
module clk_src_status #(
  parameter int NSRC     = 11,
  parameter int SEL_W    = 4,
  parameter int RATE_W   = 8,
  parameter int SLIP_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   lock_async,
  input  logic [NSRC-1:0]   slip_pulse,
  input  logic [SEL_W-1:0]  cur_src,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              rd_block,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              ev_ext_lock,
  output logic              ev_cur_lock
);

  localparam int PAD_W = 2 ** SEL_W;

  logic [NSRC-1:0]  sync_a, lock_s, lock_d, slip_r;
  logic [PAD_W-1:0] lock_pad;
  logic             cur_lock, cur_lock_r, clr_slip;
  logic [31:0]      sum_word, cur_word;

  // two-flop synchronizer, plus one delay for change detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      lock_s <= '0;
      lock_d <= '0;
    end else begin
      sync_a <= lock_async;
      lock_s <= sync_a;
      lock_d <= lock_s;
    end
  end

  assign ev_ext_lock = |(lock_s ^ lock_d);

  // sources past NSRC are treated as the internal, always-locked clock
  assign lock_pad = PAD_W'(lock_s) | ~PAD_W'({NSRC{1'b1}});
  assign cur_lock = lock_pad[cur_src];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lock_r  <= 1'b0;
      ev_cur_lock <= 1'b0;
    end else begin
      cur_lock_r  <= cur_lock;
      ev_cur_lock <= cur_lock ^ cur_lock_r;
    end
  end

  assign clr_slip = rd_en & ~rd_sel & ~rd_block;

  always_ff @(posedge clk) begin
    if (!rst_n) slip_r <= '0;
    else        slip_r <= (slip_r & ~{NSRC{clr_slip}}) | slip_pulse;
  end

  always_comb begin
    sum_word = '0;
    sum_word[NSRC-1:0] = lock_s;
    sum_word[SLIP_LSB +: NSRC] = slip_r;
    cur_word = '0;
    cur_word[0] = cur_lock_r;
    cur_word[8 +: RATE_W] = rate_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_sel ? cur_word : sum_word;
    end
  end

  assert_slip_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|slip_pulse) |=> ((slip_r & $past(slip_pulse)) == $past(slip_pulse)));

  assert_block_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && rd_block) |=> ((slip_r & $past(slip_r)) == $past(slip_r)));

  assert_lock_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_s != $past(lock_s)) |-> ev_ext_lock);

  assert_cur_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lock_r != $past(cur_lock_r)) |-> ev_cur_lock);

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_data[30:27] == 4'd0) |-> (rd_data[31] == 1'b0));

  assert_cur_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel) |=> (rd_data[7:1] == 7'd0 && rd_data[31:16] == 16'd0));

endmodule

// File: tb/tb_clk_src_status.sv
module tb_clk_src_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] lock_async = '0, slip_pulse = '0;
  logic [3:0]  cur_src = '0;
  logic [7:0]  rate_code = '0;
  logic        rd_en = 1'b0, rd_sel = 1'b0, rd_block = 1'b0;
  logic        rd_valid, ev_ext_lock, ev_cur_lock;
  logic [31:0] rd_data;

  int errors = 0, checks = 0;
  logic [10:0] exp_lock = '0, exp_slip = '0;
  logic [31:0] got;

  clk_src_status dut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_read(input logic sel, input logic blk, output logic [31:0] d);
    rd_en = 1'b1; rd_sel = sel; rd_block = blk;
    step();
    rd_en = 1'b0; rd_block = 1'b0;
    check("R9 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  function automatic logic [31:0] sum_exp();
    return {5'd0, exp_slip, 5'd0, exp_lock};
  endfunction

  task automatic set_lock(input logic [10:0] v);
    logic changed;
    changed = (v != exp_lock);
    lock_async = v;
    step();
    step();
    check("R6 ev_ext_lock on change", {31'd0, ev_ext_lock}, {31'd0, changed});
    exp_lock = v;
    step();
    check("R6 ev_ext_lock one cycle", {31'd0, ev_ext_lock}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ev_ext_lock", {31'd0, ev_ext_lock}, 32'd0);
    check("R10 ev_cur_lock", {31'd0, ev_cur_lock}, 32'd0);
    do_read(1'b0, 1'b0, got); check("R10 summary word", got, 32'd0);
    do_read(1'b1, 1'b0, got); check("R10 selected word", got, 32'd0);

    // R1 and R6: each source alone, then all, then none
    for (int i = 0; i < 11; i++) begin
      set_lock(11'(1 << i));
      do_read(1'b0, 1'b1, got); check("R1 lock bit position", got, sum_exp());
    end
    set_lock(11'h7FF);
    do_read(1'b0, 1'b0, got); check("R1 all locked", got, sum_exp());
    set_lock(11'h000);
    set_lock(11'h000);

    // R2, R3, R4, R6: each slip bit
    for (int i = 0; i < 11; i++) begin
      slip_pulse = 11'(1 << i);
      step();
      slip_pulse = '0;
      check("R6 no event from slip", {31'd0, ev_ext_lock}, 32'd0);
      exp_slip = 11'(1 << i);
      do_read(1'b0, 1'b1, got); check("R4 block read value", got, sum_exp());
      do_read(1'b0, 1'b1, got); check("R4 block read keeps slip", got, sum_exp());
      do_read(1'b0, 1'b0, got); check("R3 quadlet read value", got, sum_exp());
      exp_slip = '0;
      do_read(1'b0, 1'b0, got); check("R3 cleared after read", got, sum_exp());
    end

    // R2: sticky across several pulses and lock activity
    slip_pulse = 11'h005; step();
    slip_pulse = 11'h400; step();
    slip_pulse = '0;
    exp_slip = 11'h405;
    set_lock(11'h0F0);
    do_read(1'b1, 1'b0, got);
    do_read(1'b0, 1'b0, got); check("R2 sticky accumulate", got, sum_exp());
    exp_slip = '0;

    // R5: pulse during clearing read
    slip_pulse = 11'h002; step(); slip_pulse = '0;
    rd_en = 1'b1; rd_sel = 1'b0; rd_block = 1'b0; slip_pulse = 11'h100;
    step();
    rd_en = 1'b0; slip_pulse = '0;
    exp_slip = 11'h002;
    check("R5 read returns prior slips", rd_data, sum_exp());
    exp_slip = 11'h100;
    do_read(1'b0, 1'b0, got); check("R5 simultaneous slip kept", got, sum_exp());
    exp_slip = '0;
    do_read(1'b0, 1'b0, got); check("R5 then cleared", got, sum_exp());

    // R7, R8: select sweep with a fixed lock pattern
    set_lock(11'h555);
    for (int s = 0; s < 16; s++) begin
      logic prev, nxt;
      prev = (cur_src >= 11) ? 1'b1 : exp_lock[cur_src];
      nxt  = (s >= 11) ? 1'b1 : exp_lock[s];
      cur_src = 4'(s);
      rate_code = 8'(s % 7);
      step();
      check("R8 ev_cur_lock on select", {31'd0, ev_cur_lock}, {31'd0, prev ^ nxt});
      do_read(1'b1, 1'b0, got);
      check("R7 selected word", got, {16'd0, rate_code, 7'd0, nxt});
    end

    // R7 rate codes incl. no-rate
    cur_src = 4'd2;
    step();
    for (int r = 0; r < 8; r++) begin
      rate_code = (r == 7) ? 8'h0A : 8'(r);
      do_read(1'b1, 1'b0, got);
      check("R7 rate field", got, {16'd0, rate_code, 7'd0, exp_lock[2]});
    end

    // R8: lock change on the selected source
    lock_async = exp_lock & ~11'h004;
    step(); step();
    check("R8 no cur event yet", {31'd0, ev_cur_lock}, 32'd0);
    exp_lock = lock_async;
    step();
    check("R8 ev_cur_lock on lock loss", {31'd0, ev_cur_lock}, 32'd1);
    step();
    check("R8 ev_cur_lock one cycle", {31'd0, ev_cur_lock}, 32'd0);
    lock_async = exp_lock ^ 11'h001;
    step(); step(); step();
    exp_lock = lock_async;
    check("R8 no event for other source", {31'd0, ev_cur_lock}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule